// File: doc/BRIEF.md
# Symmetric Filter Folded Pre-Adder Datapath

This block is the folded sample path of a symmetric FIR filter. Samples enter a forward chain of four delay stages, turn around, and come back through a reverse chain of four delay stages. At every tap position a small ALU combines one forward sample with the reverse sample that shares its coefficient. This halves the number of multipliers needed downstream. Multiplication, the adder tree and any data reversal sit outside the block.

Every delay stage holds 1 to 16 words, set at run time. With interleaved channels, one stage delays a single channel by one sample period. The turnaround point depends on the configuration. An even tap count takes the output of the last forward stage. An odd tap count takes that stage's next outgoing word one step early. Odd-tap interleaved operation takes the output of the next-to-last forward stage. In both odd modes the centre sample reaches both inputs of the last ALU together, so the coefficient applied downstream to that lane must be halved. The user issues a synchronous flush after any change of length or tap mode. The ALU operation and the input gating may change on any cycle.

Top module: `fpa_datapath`

## Requirements
- R1: Reset or `flush` zeroes all delay storage and all lane outputs. When `flush` and `in_valid` are high in the same cycle, the flush wins and the sample is discarded.
- R2: Delay storage moves only on cycles with `in_valid` high. While `in_valid` stays low and the configuration is unchanged, the lane outputs hold their values.
- R3: The 4-bit `stage_len` code n gives every delay stage a delay of n+1 words: code 0 gives 1 word and code 15 gives 16 words.
- R4: Even mode (`tap_odd`=0), with L = n+1 and s valid samples x[0..s-1] since the last flush (x at a negative index reads as 0): lane k receives A = x[s-L(k+1)] and B = x[s-4L-L(4-k)]. The reverse chain is fed from the output of the last forward stage.
- R5: Odd mode (`tap_odd`=1, `odd_ilv`=0): lane k receives A = x[s-L(k+1)] and B = x[s-(4L-1)-L(4-k)]. With L=1, lane 3 sees the same sample on A and B.
- R6: Odd interleave mode (`tap_odd`=1, `odd_ilv`=1): lane k receives A = x[s-L(k+1)] and B = x[s-3L-L(4-k)]. Lane 3 sees the same sample on A and B for every L.
- R7: `odd_ilv` has no effect while `tap_odd`=0.
- R8: With `alu_sub`=0 the lane result is A+B. With `alu_sub`=1 it is B−A. Samples are 10-bit two's complement and results are 11-bit two's complement, exact for all inputs, including -512 and 511.
- R9: `pass_a`=0 replaces A with 0 and `pass_b`=0 replaces B with 0, in every lane.
- R10: Lane k occupies `lane_sum[11k+10:11k]`. It is registered and shows the storage and the ALU controls present one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of all delay storage and lane outputs |
| in_valid | input | 1 | Sample strobe; delay stages shift when high |
| in_sample | input | 10 | Two's complement input sample |
| tap_odd | input | 1 | 0 = even tap count, 1 = odd tap count |
| odd_ilv | input | 1 | Odd-tap interleave turnaround (only with tap_odd=1) |
| alu_sub | input | 1 | 0 = A+B, 1 = B−A |
| pass_a | input | 1 | 0 forces forward ALU input to zero |
| pass_b | input | 1 | 0 forces reverse ALU input to zero |
| stage_len | input | 4 | Delay stage length code, words = code+1 |
| lane_sum | output | 44 | Four registered 11-bit lane results, lane 0 lowest |

## Verification
A flush and a valid sample can arrive in the same cycle. The bench drives both strobes together with a non-zero sample. It first checks that all lanes read zero. It then pushes fresh samples and checks that every lane result matches a history that holds no trace of the discarded value. The ALU controls can change in the same cycle as a shift. The bench changes them on every pushed sample, so each result must combine the new operation with the newly shifted storage.

// File: rtl/fpa_pkg.sv
package fpa_pkg;

    // Source of the word fed into the reverse chain
    typedef enum logic [1:0] {
        TURN_EVEN   = 2'd0,
        TURN_ODD    = 2'd1,
        TURN_ODD_IL = 2'd2
    } turn_e;

    // Per-lane ALU controls
    typedef struct packed {
        logic sub;
        logic use_a;
        logic use_b;
    } alu_op_t;

    function automatic turn_e pick_turn(input logic odd, input logic ilv);
        if (!odd) return TURN_EVEN;
        if (ilv)  return TURN_ODD_IL;
        return TURN_ODD;
    endfunction

endpackage

// File: rtl/fpa_delay_line.sv
module fpa_delay_line #(
    parameter int W     = 10,
    parameter int DEPTH = 16,
    parameter int LW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          en,
    input  logic [LW-1:0] len,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [W-1:0]  dnext
);

    logic [W-1:0] word_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst || clr)
                    word_q[0] <= '0;
                else if (en)
                    word_q[0] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst || clr)
                    word_q[i] <= '0;
                else if (en)
                    word_q[i] <= word_q[i-1];
            end
        end
    end

    // Oldest word for the selected length, and the word that leaves next
    assign dout  = word_q[len];
    assign dnext = (len == '0) ? din : word_q[len - 1'b1];

endmodule

// File: rtl/fpa_alu_lane.sv
module fpa_alu_lane
    import fpa_pkg::*;
#(
    parameter int W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  alu_op_t             op,
    input  logic [W-1:0]        fwd,
    input  logic [W-1:0]        rev,
    output logic signed [W:0]   sum_q
);

    logic signed [W:0] a_x;
    logic signed [W:0] b_x;
    logic signed [W:0] res;

    always_comb begin
        a_x = op.use_a ? $signed({fwd[W-1], fwd}) : '0;
        b_x = op.use_b ? $signed({rev[W-1], rev}) : '0;
        res = op.sub ? (b_x - a_x) : (a_x + b_x);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            sum_q <= '0;
        else
            sum_q <= res;
    end

endmodule

// File: rtl/fpa_datapath.sv
module fpa_datapath
    import fpa_pkg::*;
#(
    parameter int SAMPLE_W  = 10,
    parameter int NUM_TAPS  = 4,
    parameter int MAX_LEN   = 16,
    localparam int LEN_W    = $clog2(MAX_LEN),
    localparam int LANE_W   = SAMPLE_W + 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         in_valid,
    input  logic [SAMPLE_W-1:0]          in_sample,
    input  logic                         tap_odd,
    input  logic                         odd_ilv,
    input  logic                         alu_sub,
    input  logic                         pass_a,
    input  logic                         pass_b,
    input  logic [LEN_W-1:0]             stage_len,
    output logic [NUM_TAPS*LANE_W-1:0]   lane_sum
);

    logic [SAMPLE_W-1:0] fwd_in  [NUM_TAPS];
    logic [SAMPLE_W-1:0] fwd_out [NUM_TAPS];
    logic [SAMPLE_W-1:0] rev_in  [NUM_TAPS];
    logic [SAMPLE_W-1:0] rev_out [NUM_TAPS];
    logic [SAMPLE_W-1:0] turn_early;
    logic [SAMPLE_W-1:0] turn_d;
    logic [NUM_TAPS*SAMPLE_W-1:0] fwd_flat;
    turn_e               turn_sel;
    alu_op_t             ops;

    assign turn_sel = pick_turn(tap_odd, odd_ilv);
    assign ops      = '{sub: alu_sub, use_a: pass_a, use_b: pass_b};

    // Turnaround from forward to reverse chain
    always_comb begin
        case (turn_sel)
            TURN_EVEN: turn_d = fwd_out[NUM_TAPS-1];
            TURN_ODD:  turn_d = turn_early;
            default:   turn_d = fwd_out[NUM_TAPS-2];
        endcase
    end

    for (genvar k = 0; k < NUM_TAPS; k++) begin : g_tap
        assign fwd_in[k] = (k == 0) ? in_sample : fwd_out[(k == 0) ? 0 : k-1];
        assign rev_in[k] = (k == 0) ? turn_d    : rev_out[(k == 0) ? 0 : k-1];
        assign fwd_flat[k*SAMPLE_W +: SAMPLE_W] = fwd_out[k];

        if (k == NUM_TAPS-1) begin : g_fwd_last
            fpa_delay_line #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_fwd (
                .clk(clk), .rst(rst), .clr(flush), .en(in_valid), .len(stage_len),
                .din(fwd_in[k]), .dout(fwd_out[k]), .dnext(turn_early)
            );
        end else begin : g_fwd_mid
            logic [SAMPLE_W-1:0] unused_next;
            fpa_delay_line #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_fwd (
                .clk(clk), .rst(rst), .clr(flush), .en(in_valid), .len(stage_len),
                .din(fwd_in[k]), .dout(fwd_out[k]), .dnext(unused_next)
            );
        end

        logic [SAMPLE_W-1:0] unused_rev_next;
        fpa_delay_line #(.W(SAMPLE_W), .DEPTH(MAX_LEN), .LW(LEN_W)) u_rev (
            .clk(clk), .rst(rst), .clr(flush), .en(in_valid), .len(stage_len),
            .din(rev_in[k]), .dout(rev_out[k]), .dnext(unused_rev_next)
        );

        logic signed [LANE_W-1:0] lane_q;
        fpa_alu_lane #(.W(SAMPLE_W)) u_alu (
            .clk(clk), .rst(rst), .clr(flush), .op(ops),
            .fwd(fwd_out[k]), .rev(rev_out[NUM_TAPS-1-k]), .sum_q(lane_q)
        );
        assign lane_sum[k*LANE_W +: LANE_W] = lane_q;
    end

endmodule

module fpa_datapath_chk #(
    parameter int W  = 10,
    parameter int NT = 4,
    parameter int LW = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic              in_valid,
    input logic              tap_odd,
    input logic              odd_ilv,
    input logic              alu_sub,
    input logic              pass_a,
    input logic              pass_b,
    input logic [LW-1:0]     stage_len,
    input logic [NT*W-1:0]   fwd_flat,
    input logic [NT*(W+1)-1:0] lane_sum
);

    logic [LW+4:0] cfg;
    assign cfg = {tap_odd, odd_ilv, alu_sub, pass_a, pass_b, stage_len};

    // R1
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (lane_sum == '0));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!in_valid && !flush) && !flush && $stable(cfg)) |=> $stable(lane_sum));

    // R9
    gate_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!pass_a && !pass_b && !flush) |=> (lane_sum == '0));

    for (genvar k = 0; k < NT; k++) begin : g_lane
        // R8
        fwd_only_chk: assert property (@(posedge clk) disable iff (rst)
            (pass_a && !pass_b && !alu_sub && !flush) |=>
            (lane_sum[k*(W+1) +: W+1] ==
             {$past(fwd_flat[k*W + W-1]), $past(fwd_flat[k*W +: W])}));
    end

endmodule

bind fpa_datapath fpa_datapath_chk #(.W(SAMPLE_W), .NT(NUM_TAPS), .LW(LEN_W)) u_chk (
    .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
    .tap_odd(tap_odd), .odd_ilv(odd_ilv), .alu_sub(alu_sub),
    .pass_a(pass_a), .pass_b(pass_b), .stage_len(stage_len),
    .fwd_flat(fwd_flat), .lane_sum(lane_sum)
);

// File: tb/fpa_datapath_bench.sv
`timescale 1ns/1ps
module fpa_datapath_bench;

    localparam int N  = 4;
    localparam int LW = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        in_valid = 1'b0;
    logic [9:0]  in_sample = '0;
    logic        tap_odd = 1'b0;
    logic        odd_ilv = 1'b0;
    logic        alu_sub = 1'b0;
    logic        pass_a = 1'b1;
    logic        pass_b = 1'b1;
    logic [3:0]  stage_len = '0;
    logic [N*LW-1:0] lane_sum;

    int hist [0:1023];
    int s_cnt = 0;
    int seg_len = 1;
    int mode = 0;        // 0 even, 1 odd, 2 odd interleave
    string tag = "R4";
    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    int unsigned seed = 32'h1234_5678;

    always #2.5 clk = ~clk;

    fpa_datapath u_fpa_datapath (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_sample(in_sample), .tap_odd(tap_odd), .odd_ilv(odd_ilv),
        .alu_sub(alu_sub), .pass_a(pass_a), .pass_b(pass_b),
        .stage_len(stage_len), .lane_sum(lane_sum)
    );

    function automatic int xv(input int i);
        return (i < 0) ? 0 : hist[i];
    endfunction

    function automatic int expect_lane(input int k);
        int d, a, b;
        d = (mode == 0) ? N*seg_len : (mode == 1) ? N*seg_len - 1 : (N-1)*seg_len;
        a = pass_a ? xv(s_cnt - seg_len*(k+1)) : 0;
        b = pass_b ? xv(s_cnt - d - seg_len*(N-k)) : 0;
        return alu_sub ? (b - a) : (a + b);
    endfunction

    task automatic check_lanes(input string req);
        for (int k = 0; k < N; k++) begin
            logic signed [LW-1:0] lv;
            int got, exp_v;
            lv = lane_sum[k*LW +: LW];     // R10 lane placement
            got = lv;
            exp_v = expect_lane(k);
            nchk++;
            if (got !== exp_v) begin
                nfail++;
                $display("FAIL %s lane %0d s=%0d L=%0d: got %0d expected %0d",
                         req, k, s_cnt, seg_len, got, exp_v);
            end
        end
    endtask

    task automatic do_flush();
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        @(negedge clk);
        s_cnt = 0;
    endtask

    // Drive one sample with new ALU controls, check after the output register
    task automatic push(input int v, input int opi);
        @(negedge clk);
        in_valid = 1'b1;
        in_sample = v[9:0];
        alu_sub = opi[0];
        pass_a = (opi % 8) != 1 && (opi % 8) != 4;
        pass_b = (opi % 8) != 2 && (opi % 8) != 5;
        @(negedge clk);
        in_valid = 1'b0;
        hist[s_cnt] = v;
        s_cnt++;
        @(negedge clk);
    endtask

    function automatic int next_val(input int i);
        seed = seed * 32'd1103515245 + 32'd12345;
        if (i % 7 == 3) return -512;
        if (i % 5 == 2) return 511;
        return int'((seed >> 16) % 1024) - 512;
    endfunction

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int lens [4] = '{1, 2, 3, 16};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check_lanes("R1");

        for (int m = 0; m < 4; m++) begin
            for (int li = 0; li < 4; li++) begin
                seg_len   = lens[li];
                stage_len = 4'(seg_len - 1);          // R3 code n gives n+1 words
                tap_odd   = (m == 1 || m == 2);
                odd_ilv   = (m == 2 || m == 3);       // m==3: R7 ilv ignored in even
                mode      = (m == 3) ? 0 : m;
                tag       = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";
                do_flush();
                check_lanes("R1");
                for (int i = 0; i < 8*seg_len + 6; i++) begin
                    push(next_val(i), i);
                    check_lanes({tag, " R3 R8 R9"});
                    if (i % 9 == 4) begin
                        // R2 idle cycles with a changing but invalid input
                        in_sample = 10'h2AA;
                        repeat (3) @(negedge clk);
                        check_lanes("R2");
                    end
                end
            end
        end

        // R1 flush and valid in the same cycle: flush wins, sample dropped
        seg_len = 1; stage_len = 4'd0; tap_odd = 1'b0; odd_ilv = 1'b0; mode = 0;
        do_flush();
        for (int i = 0; i < 5; i++) push(100 + i, 0);
        @(negedge clk);
        flush = 1'b1; in_valid = 1'b1; in_sample = 10'd77;
        @(negedge clk);
        flush = 1'b0; in_valid = 1'b0;
        @(negedge clk);
        s_cnt = 0;
        check_lanes("R1");
        for (int i = 0; i < 10; i++) begin
            push(-3 * i - 1, 0);
            check_lanes("R1 R4");
        end

        // R8 extremes: sum and difference of full-scale values
        do_flush();
        for (int i = 0; i < 12; i++) begin
            push((i % 2 == 0) ? -512 : 511, (i % 2 == 0) ? 0 : 1);
            check_lanes("R8");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule